// File: doc/BRIEF.md
# Debug Port Status Priority Reporter

This block is the outgoing-status half of a serial debug link between an external tool and a CPU. The tool supplies the serial clock. Each frame, the block shifts a 2-bit status code and a 32-bit payload out on `tdo_o`. At the same time it shifts a new 34-bit word in on `tdi_i`. The status is picked by fixed priority from four possibilities:

- a data word the CPU has written for the tool
- a sequencing error
- an interrupt
- nothing to report

Events that lose the arbitration stay pending and go out on a later frame.

When a frame ends, the block decides what to do with the word it shifted in. If that frame reported a sequencing error or an interrupt, the word is dropped. Otherwise the word is checked against what the CPU is waiting for. A word of the right kind is handed to the CPU with a one-cycle strobe. A word of the wrong kind raises a new sequencing error. If the CPU was waiting for data, that case also returns a bus-error pulse to the CPU.

Top module: `dbg_stat_port`

## Requirements
- R1: A frame is 34 enabled serial clocks. `tdi_i` is sampled on rising edges of `clk_i` and `tdo_o` changes only on falling edges. The output bit for the k-th enabled rising edge of a frame is driven after that edge. Clocks with `frame_en_i` low neither advance the frame nor change `tdo_o`.
- R2: Output frame layout:
  - two status bits, most significant first
  - then the 32-bit payload, least significant bit first
  - status codes: 00 CPU data, 01 sequencing error, 10 interrupt, 11 nothing to report
- R3: A pending CPU word (loaded with `cpu_wr_i`/`cpu_wdata_i`) has top priority and goes out as the payload with status 00. With nothing pending, status 11 is sent with an all-zero payload.
- R4: An interrupt that is pending at the same time as CPU data is held and reported on the next frame.
- R5: A sequencing error wins over an interrupt. With both pending, the error goes out first and the interrupt on the following frame.
- R6: The status is chosen at the first enabled clock of a frame, from events registered before that clock. A pending event is cleared only by the frame that reports it. An event arriving in the first clock of a frame or later is reported no earlier than the next frame.
- R7: Input frame layout:
  - bit 0: word kind (1 data, 0 instruction)
  - bit 1: ignored
  - bits 2..33: the 32-bit word, least significant bit first

  On an accepted frame, `rx_valid_o` is high for exactly one cycle after the last edge. In that same cycle `rx_word_o` and `rx_is_data_o` present the word.
- R8: When a frame's outgoing status is 01 or 10, its incoming word is discarded. No `rx_valid_o` is issued and `rx_word_o` is unchanged.
- R9: On a frame that is otherwise accepted, the kind check applies when `cpu_wait_i` is high and the received kind differs from `cpu_want_data_i`. In that case:
  - the word is not delivered
  - a sequencing error becomes pending
  - if `cpu_want_data_i` is 1, `bus_err_o` pulses for one cycle
- R10: `rst_ni` low clears all pending events and the frame position. It drives `tdo_o` high and `rx_valid_o` and `bus_err_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock from the tool |
| rst_ni | input | 1 | Asynchronous active-low reset |
| frame_en_i | input | 1 | Frame clock enable; low pauses the frame |
| tdi_i | input | 1 | Serial input from the tool |
| tdo_o | output | 1 | Serial status and payload output |
| cpu_wr_i | input | 1 | CPU loads a word for the tool |
| cpu_wdata_i | input | 32 | Word written by the CPU |
| irq_i | input | 1 | Interrupt event from the CPU |
| cpu_wait_i | input | 1 | CPU is waiting for an input word |
| cpu_want_data_i | input | 1 | CPU wants data (1) or an instruction (0) |
| rx_valid_o | output | 1 | One-cycle strobe for an accepted input word |
| rx_is_data_o | output | 1 | Kind of the delivered word |
| rx_word_o | output | 32 | Delivered input word |
| bus_err_o | output | 1 | One-cycle bus-error pulse on a data-read mismatch |

## Verification
The bench targets several corner cases:
- **Data write and interrupt in the same cycle.** A design that lets the interrupt pre-empt the data, or drops it, would show status 10 first or never show it.
- **Both mismatch directions while the CPU waits.** A wrong design would deliver the bad word, or pulse the bus error in the instruction case.
- **Discarding on error and interrupt frames.** A leaky design would strobe `rx_valid_o` or overwrite `rx_word_o`.
- **Events arriving in the first clock of a frame.** These must land on the next frame.
- **Pauses in the middle of a frame.** These must freeze both the frame position and `tdo_o`.
- **Reset with events pending.**

// File: rtl/dbg_stat_pkg.sv
package dbg_stat_pkg;
  typedef enum logic [1:0] {
    ST_VALID  = 2'b00,
    ST_SEQERR = 2'b01,
    ST_INTR   = 2'b10,
    ST_NULL   = 2'b11
  } dbg_status_e;
endpackage

// File: rtl/dbg_stat_frame_ctr.sv
module dbg_stat_frame_ctr #(
  parameter int LEN = 34,
  localparam int CW = $clog2(LEN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic          start_o,
  output logic          last_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  assign start_o = en_i && (cnt_q == '0);
  assign last_o  = en_i && (cnt_q == CW'(LEN-1));
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (last_o)  cnt_q <= '0;
    else if (en_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dbg_stat_arbiter.sv
module dbg_stat_arbiter
  import dbg_stat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              irq_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              seq_set_i,
  output dbg_status_e       status_o,
  output logic [DATA_W-1:0] payload_o
);
  logic              full_q, seq_q, int_q;
  logic [DATA_W-1:0] data_q;

  // fixed priority over registered flags only
  always_comb begin
    if (full_q)     status_o = ST_VALID;
    else if (seq_q) status_o = ST_SEQERR;
    else if (int_q) status_o = ST_INTR;
    else            status_o = ST_NULL;
    payload_o = full_q ? data_q : '0;
  end

  logic sent_data, sent_seq, sent_int;
  assign sent_data = take_i && (status_o == ST_VALID);
  assign sent_seq  = take_i && (status_o == ST_SEQERR);
  assign sent_int  = take_i && (status_o == ST_INTR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      seq_q  <= 1'b0;
      int_q  <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= (full_q && !sent_data) || wr_i;
      seq_q  <= (seq_q  && !sent_seq)  || seq_set_i;
      int_q  <= (int_q  && !sent_int)  || irq_i;
      if (wr_i) data_q <= wdata_i;
    end
  end
endmodule

// File: rtl/dbg_stat_rx.sv
module dbg_stat_rx #(
  parameter int DATA_W = 32,
  parameter int ST_W   = 2,
  localparam int FL    = ST_W + DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tdi_i,
  output logic [FL-1:0] frame_o
);
  logic [FL-1:0] sh_q;

  // first received bit ends up at index 0
  assign frame_o = {tdi_i, sh_q[FL-1:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sh_q <= '0;
    else if (en_i) sh_q <= frame_o;
  end
endmodule

// File: rtl/dbg_stat_tx.sv
module dbg_stat_tx #(
  parameter int DATA_W = 32,
  parameter int ST_W   = 2,
  localparam int FL    = ST_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [ST_W-1:0]   status_i,
  input  logic [DATA_W-1:0] payload_i,
  output logic              tdo_o
);
  logic [FL-1:0] frame, tx_q;
  logic          tdo_q;

  always_comb begin
    for (int j = 0; j < ST_W; j++)   frame[j] = status_i[ST_W-1-j];
    for (int i = 0; i < DATA_W; i++) frame[ST_W+i] = payload_i[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     tx_q <= '1;
    else if (load_i) tx_q <= frame;
    else if (en_i)   tx_q <= {1'b1, tx_q[FL-1:1]};
  end

  // launch on the falling edge, tool samples on the rising edge
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tdo_q <= 1'b1;
    else         tdo_q <= tx_q[0];
  end

  assign tdo_o = tdo_q;
endmodule

// File: rtl/dbg_stat_port.sv
module dbg_stat_port
  import dbg_stat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_en_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  input  logic              cpu_wr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              irq_i,
  input  logic              cpu_wait_i,
  input  logic              cpu_want_data_i,
  output logic              rx_valid_o,
  output logic              rx_is_data_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              bus_err_o
);
  localparam int ST_W = 2;
  localparam int FL   = ST_W + DATA_W;
  localparam int CW   = $clog2(FL);

  logic              start, last;
  logic [CW-1:0]     cnt;
  dbg_status_e       status;
  logic [DATA_W-1:0] payload;
  logic [FL-1:0]     rx_frame;
  logic              accept_q;
  logic              mismatch, seq_set;

  dbg_stat_frame_ctr #(.LEN(FL)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (frame_en_i),
    .start_o (start),
    .last_o  (last),
    .cnt_o   (cnt)
  );

  dbg_stat_arbiter #(.DATA_W(DATA_W)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .take_i    (start),
    .irq_i     (irq_i),
    .wr_i      (cpu_wr_i),
    .wdata_i   (cpu_wdata_i),
    .seq_set_i (seq_set),
    .status_o  (status),
    .payload_o (payload)
  );

  dbg_stat_tx #(.DATA_W(DATA_W), .ST_W(ST_W)) u_tx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (frame_en_i),
    .load_i    (start),
    .status_i  (status),
    .payload_i (payload),
    .tdo_o     (tdo_o)
  );

  dbg_stat_rx #(.DATA_W(DATA_W), .ST_W(ST_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (frame_en_i),
    .tdi_i   (tdi_i),
    .frame_o (rx_frame)
  );

  // word is kept only when the outgoing status was data or null
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    accept_q <= 1'b0;
    else if (start) accept_q <= (status == ST_VALID) || (status == ST_NULL);
  end

  assign mismatch = cpu_wait_i && (rx_frame[0] != cpu_want_data_i);
  assign seq_set  = last && accept_q && mismatch;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_o   <= 1'b0;
      bus_err_o    <= 1'b0;
      rx_is_data_o <= 1'b0;
      rx_word_o    <= '0;
    end else begin
      rx_valid_o <= last && accept_q && !mismatch;
      bus_err_o  <= seq_set && cpu_want_data_i;
      if (last && accept_q && !mismatch) begin
        rx_is_data_o <= rx_frame[0];
        rx_word_o    <= rx_frame[FL-1:ST_W];
      end
    end
  end

  logic unused_cnt;
  assign unused_cnt = ^{cnt, rx_frame[1]};
endmodule

// File: rtl/dbg_stat_port_chk.sv
module dbg_stat_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic frame_en_i,
  input logic cpu_wait_i,
  input logic cpu_want_data_i,
  input logic tdo_o,
  input logic rx_valid_o,
  input logic bus_err_o,
  input logic accept_q
);
  // R1
  pause_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(frame_en_i) |-> $stable(tdo_o));

  // R7
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  // R8
  discard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(accept_q));

  // R9
  berr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_valid_o && bus_err_o));

  // R9
  berr_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_o |-> $past(cpu_wait_i && cpu_want_data_i));
endmodule

bind dbg_stat_port dbg_stat_port_chk u_chk (.*);

// File: tb/tb_dbg_stat_port.sv
module tb_dbg_stat_port;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        frame_en_i = 1'b0, tdi_i = 1'b0;
  logic        cpu_wr_i = 1'b0, irq_i = 1'b0;
  logic [31:0] cpu_wdata_i = '0;
  logic        cpu_wait_i = 1'b0, cpu_want_data_i = 1'b0;
  logic        tdo_o, rx_valid_o, rx_is_data_o, bus_err_o;
  logic [31:0] rx_word_o;

  dbg_stat_port dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int    checks = 0, failures = 0;
  string tag = "R1";

  // reference model state
  bit          m_full, m_seq, m_int, m_acc;
  logic [31:0] m_data;
  int          m_cnt;
  bit          out_q[$];
  bit          rx_q[$];
  logic        e_tdo, e_rxv, e_berr, e_kind;
  logic [31:0] e_word;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_full = 0; m_seq = 0; m_int = 0; m_acc = 0; m_data = '0; m_cnt = 0;
    out_q.delete(); rx_q.delete();
    e_tdo = 1'b1; e_rxv = 1'b0; e_berr = 1'b0; e_kind = 1'b0; e_word = '0;
  endtask

  task automatic tick();
    bit seq_new = 0;
    e_rxv = 1'b0; e_berr = 1'b0;
    if (frame_en_i) begin
      if (m_cnt == 0) begin
        logic [1:0]  st;
        logic [31:0] pl;
        if (m_full)     begin st = 2'b00; pl = m_data; m_full = 0; end
        else if (m_seq) begin st = 2'b01; pl = '0; m_seq = 0; end
        else if (m_int) begin st = 2'b10; pl = '0; m_int = 0; end
        else            begin st = 2'b11; pl = '0; end
        m_acc = (st == 2'b00) || (st == 2'b11);
        out_q.delete();
        out_q.push_back(st[1]); out_q.push_back(st[0]);
        for (int i = 0; i < 32; i++) out_q.push_back(pl[i]);
      end
      rx_q.push_back(tdi_i);
      e_tdo = out_q.pop_front();
      if (m_cnt == 33) begin
        if (m_acc) begin
          logic [31:0] w;
          for (int i = 0; i < 32; i++) w[i] = rx_q[2+i];
          if (cpu_wait_i && (rx_q[0] != cpu_want_data_i)) begin
            seq_new = 1; e_berr = cpu_want_data_i;
          end else begin
            e_rxv = 1'b1; e_word = w; e_kind = rx_q[0];
          end
        end
        rx_q.delete();
        m_cnt = 0;
      end else m_cnt++;
    end
    if (irq_i) m_int = 1;
    if (cpu_wr_i) begin m_full = 1; m_data = cpu_wdata_i; end
    if (seq_new) m_seq = 1;
    @(negedge clk_i); #1;
    chk(tag, "tdo", tdo_o, e_tdo);
    chk(tag, "rx_valid", rx_valid_o, e_rxv);
    chk(tag, "bus_err", bus_err_o, e_berr);
    chk(tag, "rx_word", rx_word_o, e_word);
    chk(tag, "rx_is_data", rx_is_data_o, e_kind);
  endtask

  task automatic idle(int n);
    frame_en_i = 0; irq_i = 0; cpu_wr_i = 0;
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic cpu_write(logic [31:0] v, bit with_irq);
    frame_en_i = 0; cpu_wr_i = 1; cpu_wdata_i = v; irq_i = with_irq;
    tick();
    cpu_wr_i = 0; irq_i = 0;
  endtask

  task automatic run_frame(input bit kind, input logic [31:0] w, input int irq_at,
                           input int wr_at, input logic [31:0] wv, input int gap_at,
                           output logic [1:0] st, output logic [31:0] pl);
    for (int k = 0; k < 34; k++) begin
      frame_en_i = 1;
      tdi_i = (k == 0) ? kind : (k == 1) ? 1'b0 : w[k-2];
      irq_i = (k == irq_at);
      cpu_wr_i = (k == wr_at);
      cpu_wdata_i = wv;
      tick();
      if (k < 2) st[1-k] = tdo_o; else pl[k-2] = tdo_o;
      if (k == gap_at) begin
        logic held;
        held = tdo_o;
        idle(3);
        chk("R1", "tdo held during pause", tdo_o, held);
      end
    end
    frame_en_i = 0; irq_i = 0; cpu_wr_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0; frame_en_i = 0; irq_i = 0; cpu_wr_i = 0;
    model_reset();
    #(CLK_PERIOD*2);
    rst_ni = 1;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    failures++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [1:0]  st;
    logic [31:0] pl, prev;
    model_reset();
    #(CLK_PERIOD*3 + 1);
    // R10 reset state
    chk("R10", "tdo in reset", tdo_o, 1'b1);
    chk("R10", "rx_valid in reset", rx_valid_o, 1'b0);
    chk("R10", "bus_err in reset", bus_err_o, 1'b0);
    rst_ni = 1;
    tag = "R2"; idle(2);

    // R3 null frame, R7 accepted data word
    run_frame(1'b1, 32'hA5A5_0F0F, -1, -1, '0, -1, st, pl);
    chk("R2", "null status", st, 2'b11);
    chk("R3", "null payload", pl, 32'h0);
    chk("R7", "rx_valid strobe", rx_valid_o, 1'b1);
    chk("R7", "rx_word", rx_word_o, 32'hA5A5_0F0F);
    chk("R7", "rx_is_data", rx_is_data_o, 1'b1);
    tag = "R7"; idle(1);
    chk("R7", "strobe one cycle", rx_valid_o, 1'b0);

    // R3 CPU data out, instruction word in
    tag = "R3";
    cpu_write(32'h1234_5678, 0);
    run_frame(1'b0, 32'h0BAD_F00D, -1, -1, '0, -1, st, pl);
    chk("R3", "valid status", st, 2'b00);
    chk("R3", "valid payload", pl, 32'h1234_5678);
    chk("R7", "instruction kind", rx_is_data_o, 1'b0);
    idle(2);

    // R4 data and interrupt together
    tag = "R4";
    cpu_write(32'hCAFE_0001, 1);
    run_frame(1'b1, 32'h1111_2222, -1, -1, '0, -1, st, pl);
    chk("R4", "data first", st, 2'b00);
    chk("R4", "data payload", pl, 32'hCAFE_0001);
    prev = rx_word_o;
    run_frame(1'b1, 32'hDEAD_BEEF, -1, -1, '0, -1, st, pl);
    chk("R4", "interrupt next", st, 2'b10);
    chk("R8", "no strobe on interrupt frame", rx_valid_o, 1'b0);
    chk("R8", "word unchanged", rx_word_o, prev);
    run_frame(1'b1, 32'h5, -1, -1, '0, -1, st, pl);
    chk("R6", "interrupt cleared once sent", st, 2'b11);
    idle(2);

    // R9 data expected, instruction sent; then R5 ordering
    tag = "R9";
    cpu_wait_i = 1; cpu_want_data_i = 1;
    run_frame(1'b0, 32'h7777_0000, -1, -1, '0, -1, st, pl);
    chk("R9", "bus error pulse", bus_err_o, 1'b1);
    chk("R9", "no strobe on mismatch", rx_valid_o, 1'b0);
    cpu_wait_i = 0;
    irq_i = 1; tick(); irq_i = 0;
    chk("R9", "bus error one cycle", bus_err_o, 1'b0);
    tag = "R5";
    prev = rx_word_o;
    run_frame(1'b1, 32'h3333_3333, -1, -1, '0, -1, st, pl);
    chk("R5", "seq error first", st, 2'b01);
    chk("R8", "seq frame word unchanged", rx_word_o, prev);
    run_frame(1'b1, 32'h4, -1, -1, '0, -1, st, pl);
    chk("R5", "interrupt after seq error", st, 2'b10);
    run_frame(1'b1, 32'h4, -1, -1, '0, -1, st, pl);
    chk("R5", "nothing left", st, 2'b11);

    // R9 instruction expected, data sent
    tag = "R9";
    cpu_wait_i = 1; cpu_want_data_i = 0;
    run_frame(1'b1, 32'h9999_0000, -1, -1, '0, -1, st, pl);
    chk("R9", "no bus error on instruction read", bus_err_o, 1'b0);
    chk("R9", "no strobe", rx_valid_o, 1'b0);
    cpu_wait_i = 0;
    run_frame(1'b0, 32'h1, -1, -1, '0, -1, st, pl);
    chk("R9", "seq error reported", st, 2'b01);

    // R6 events at/after frame start wait for the next frame
    tag = "R6";
    run_frame(1'b0, 32'h2, 0, 20, 32'h0F0F_1234, -1, st, pl);
    chk("R6", "start-cycle event deferred", st, 2'b11);
    run_frame(1'b0, 32'h2, -1, -1, '0, -1, st, pl);
    chk("R6", "deferred data next", st, 2'b00);
    chk("R6", "deferred payload", pl, 32'h0F0F_1234);
    run_frame(1'b0, 32'h2, -1, -1, '0, -1, st, pl);
    chk("R6", "deferred interrupt after data", st, 2'b10);

    // R1 pauses inside a frame
    tag = "R1";
    cpu_write(32'h8000_0001, 0);
    run_frame(1'b1, 32'hFEDC_BA98, -1, -1, '0, 5, st, pl);
    chk("R1", "paused frame status", st, 2'b00);
    chk("R1", "paused frame payload", pl, 32'h8000_0001);
    chk("R1", "paused frame word", rx_word_o, 32'hFEDC_BA98);

    // R10 reset drops pending events
    tag = "R10";
    cpu_write(32'h1, 1);
    do_reset();
    run_frame(1'b1, 32'h6, -1, -1, '0, -1, st, pl);
    chk("R10", "pending cleared by reset", st, 2'b11);
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule